// File: doc/BRIEF.md
# Scanline Interrupt Counter Driven by Pattern-Address Line 12

This block counts scanlines for a cartridge banking controller by watching bit 12 of the picture processor's pattern-fetch address. Each qualified rising edge of that bit is one scanline tick. An 8-bit down-counter steps on each tick. When the counter lands on zero while interrupts are enabled, the block raises a level interrupt request toward the processor. Software sets the reload value and requests reloads through a small write-only register window. Software also enables the interrupt, and acknowledges it by disabling it.

The enclosing controller has several personalities, chosen by a 2-bit mode input. The counter ticks, and its registers accept writes, only in personality `01`. In every other personality, A12 activity and register writes leave the block unchanged. The block runs on one clock. A12 and the write strobe are both sampled on its rising edge. A rise of A12 counts only after A12 has stayed low for a parameterised number of clocks. This filter rejects the quick toggles that sprite fetches produce.

Top module: `a12_irq_counter`

## Requirements
- R1: After reset, `irq` is low, the counter and the reload value are zero, interrupts are disabled and no reload is pending. The first qualified rise with interrupts enabled therefore loads zero and raises `irq`.
- R2: An A12 rise is qualified only when `a12` was sampled low on at least `LOW_MIN` consecutive clock edges just before the edge where it is first sampled high. Shorter low periods give no tick. Low edges are counted from the release of reset.
- R3: Ticks and register writes act only while `mode` equals `2'b01`. In any other mode, A12 rises and writes change nothing.
- R4: On a tick, the counter loads the reload value if it is zero or a reload is pending. Otherwise it decrements by one.
- R5: If the counter is zero after a tick's update and interrupts are enabled, `irq` is high from the next clock on.
- R6: The pending-reload flag is cleared by every tick.
- R7: Writes are decoded on `wr_addr & 16'hE001`. `16'hC000` stores `wr_data` as the reload value. `16'hC001` sets the pending-reload flag. `16'hE000` disables interrupts and drops `irq`. `16'hE001` enables interrupts.
- R8: `irq` is a level. It stays high through further ticks, falling edges of A12 and enable writes, until a disable write.
- R9: When a write and a tick land on the same edge, the tick uses the old register state. After that, the write takes effect. So a disable write leaves `irq` low, and a reload request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for A12 and the write strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Controller personality; `01` enables the counter |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 16 | Processor write address |
| wr_data | input | 8 | Processor write data |
| a12 | input | 1 | Bit 12 of the pattern-fetch address |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is a rise that arrives on exactly the edge where the filter's low count reaches its limit, or on the same edge as a register write. In those cases, being off by one clock changes whether the counter moves at all. The stimulus builds A12 pulse trains with low times of exactly `LOW_MIN - 1` and `LOW_MIN` clocks. It also merges a disable write or a reload request into the very cycle where A12 first goes high. A count model inside the bench, stepped once per clock, predicts the `irq` level for every cycle of those trains.

// File: rtl/a12_irq_counter.sv
module a12_irq_counter #(
  parameter int CNT_W   = 8,
  parameter int LOW_MIN = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             a12,
  output logic             irq
);
  localparam int LOW_W = $clog2(LOW_MIN + 1);
  localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(LOW_MIN);

  logic [LOW_W-1:0] low_cnt;
  logic [CNT_W-1:0] cnt, latch;
  logic             pend, en;

  wire        active = (mode == 2'b01);
  wire [15:0] dec    = wr_addr & 16'hE001;
  wire        wr_ok  = wr_en & active;
  wire        w_lat  = wr_ok & (dec == 16'hC000);
  wire        w_rld  = wr_ok & (dec == 16'hC001);
  wire        w_dis  = wr_ok & (dec == 16'hE000);
  wire        w_ena  = wr_ok & (dec == 16'hE001);

  wire             tick   = active & a12 & (low_cnt == LOW_LIM);
  wire [CNT_W-1:0] cnt_nx = ((cnt == '0) || pend) ? latch : cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
      cnt     <= '0;
      latch   <= '0;
      pend    <= 1'b0;
      en      <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (a12)                     low_cnt <= '0;
      else if (low_cnt != LOW_LIM) low_cnt <= low_cnt + 1'b1;

      if (tick)  cnt   <= cnt_nx;
      if (w_lat) latch <= wr_data;

      if (w_rld)     pend <= 1'b1;
      else if (tick) pend <= 1'b0;

      if (w_dis)      en <= 1'b0;
      else if (w_ena) en <= 1'b1;

      if (w_dis)                              irq <= 1'b0;
      else if (tick && cnt_nx == '0 && en)    irq <= 1'b1;
    end
  end
endmodule

// File: rtl/a12_irq_counter_chk.sv
module a12_irq_counter_chk #(
  parameter int CNT_W   = 8,
  parameter int LOW_MIN = 10,
  parameter int LOW_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             wr_en,
  input logic [15:0]      wr_addr,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [LOW_W-1:0] low_cnt,
  input logic             en
);
  wire ack = wr_en && mode == 2'b01 && (wr_addr & 16'hE001) == 16'hE000;

  assert_short_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(low_cnt) < LOW_MIN) |=> $stable(cnt));
  assert_low_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(low_cnt) <= LOW_MIN);
  assert_mode_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |=> ($stable(cnt) && $stable(irq) && $stable(en)));
  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cnt == '0 && en));
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
endmodule

bind a12_irq_counter a12_irq_counter_chk #(
  .CNT_W(CNT_W), .LOW_MIN(LOW_MIN), .LOW_W(LOW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_addr(wr_addr),
  .irq(irq), .cnt(cnt), .low_cnt(low_cnt), .en(en)
);

// File: tb/sim_a12_irq_counter.sv
`timescale 1ns/1ps
module sim_a12_irq_counter;
  localparam int LOW_MIN = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        a12 = 1'b0;
  logic        irq;

  int checks = 0, fails = 0;
  bit    q_exp[$];
  string q_tag[$];
  string tag = "R1";
  bit    done = 1'b0;

  int m_low = 0, m_cnt = 0, m_lat = 0;
  bit m_pend = 0, m_en = 0, m_irq = 0;

  always #4 clk = ~clk;

  a12_irq_counter #(.CNT_W(8), .LOW_MIN(LOW_MIN)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .a12(a12), .irq(irq)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (q_exp.size() > 0) begin
        bit e; string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (irq !== e) begin
          fails++;
          $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
        end
      end
    end
  end

  task automatic cyc(input bit a, input bit w, input logic [15:0] ad, input logic [7:0] d);
    bit q;
    int nx;
    a12 = a; wr_en = w; wr_addr = ad; wr_data = d;
    q = (mode == 2'b01) && a && (m_low >= LOW_MIN);
    if (q) begin
      nx = (m_cnt == 0 || m_pend) ? m_lat : (m_cnt - 1);
      m_cnt = nx;
      if (nx == 0 && m_en) m_irq = 1;
      m_pend = 0;
    end
    m_low = a ? 0 : m_low + 1;
    if (w && mode == 2'b01) begin
      case (ad & 16'hE001)
        16'hC000: m_lat = d;
        16'hC001: m_pend = 1;
        16'hE000: begin m_en = 0; m_irq = 0; end
        16'hE001: m_en = 1;
        default: ;
      endcase
    end
    @(posedge clk);
    q_exp.push_back(m_irq);
    q_tag.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [15:0] ad, input logic [7:0] d);
    cyc(1'b0, 1'b1, ad, d);
  endtask

  task automatic pulse(input int lo, input int hi);
    for (int i = 0; i < lo; i++) cyc(1'b0, 1'b0, 16'h0, 8'h0);
    for (int i = 0; i < hi; i++) cyc(1'b1, 1'b0, 16'h0, 8'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R1 reset irq actual=%0b expected=0", irq); end
    rst_n = 1'b1;

    tag = "R1";
    pulse(3, 0);
    wr(16'hE001, 0);
    pulse(12, 2);
    tag = "R7";
    wr(16'hE000, 0);

    tag = "R4";
    wr(16'hC000, 3);
    wr(16'hE001, 0);
    for (int i = 0; i < 4; i++) pulse(12, 2);
    tag = "R8";
    pulse(12, 2);
    pulse(12, 3);
    wr(16'hE001, 0);
    pulse(4, 4);
    wr(16'hE000, 0);

    tag = "R2";
    wr(16'hE001, 0);
    for (int i = 0; i < 4; i++) pulse(5, 1);
    pulse(LOW_MIN - 1, 1);
    pulse(LOW_MIN - 1, 2);
    pulse(LOW_MIN, 1);
    for (int i = 0; i < 5; i++) pulse(LOW_MIN, 1);
    tag = "R5";
    wr(16'hE000, 0);
    wr(16'hE001, 0);
    for (int i = 0; i < 5; i++) pulse(LOW_MIN, 1);
    wr(16'hE000, 0);

    tag = "R6";
    wr(16'hE001, 0);
    wr(16'hC000, 5);
    wr(16'hC001, 0);
    pulse(12, 1);
    pulse(12, 1);
    wr(16'hC001, 0);
    pulse(12, 1);
    for (int i = 0; i < 6; i++) pulse(12, 1);
    wr(16'hE000, 0);

    tag = "R3";
    mode = 2'b10;
    for (int i = 0; i < 10; i++) pulse(12, 1);
    wr(16'hE001, 0);
    wr(16'hC000, 0);
    mode = 2'b01;
    for (int i = 0; i < 7; i++) pulse(12, 1);
    wr(16'hE001, 0);
    for (int i = 0; i < 7; i++) pulse(12, 1);
    mode = 2'b11;
    wr(16'hE000, 0);
    pulse(12, 2);
    mode = 2'b00;
    wr(16'hE002, 0);
    pulse(12, 2);
    mode = 2'b01;
    pulse(2, 0);

    tag = "R7";
    wr(16'hE002, 0);
    wr(16'hDFFE, 1);
    wr(16'hFFFF, 0);
    for (int i = 0; i < 3; i++) pulse(12, 1);
    wr(16'hE0FE, 0);
    wr(16'hC0FF, 0);
    wr(16'hA001, 0);
    wr(16'hE001, 0);
    for (int i = 0; i < 4; i++) pulse(12, 1);
    wr(16'hE000, 0);

    tag = "R9";
    wr(16'hC000, 0);
    wr(16'hE001, 0);
    pulse(12, 0);
    cyc(1'b1, 1'b1, 16'hE000, 0);
    pulse(2, 0);
    wr(16'hE001, 0);
    wr(16'hC000, 2);
    pulse(12, 0);
    cyc(1'b1, 1'b1, 16'hC001, 0);
    pulse(12, 1);
    pulse(12, 1);
    pulse(12, 1);
    pulse(12, 1);
    pulse(3, 0);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule